// File: doc/BRIEF.md
# Lockable I/O-Port ROM Bank Mapper

This block sits on the cartridge side of an 8-bit microprocessor bus and selects which 32 KB bank of a 1 MB ROM image the CPU sees. Any I/O access whose address has bits 7..3 all zero hits the mapper, so the eight ports 0..7 are aliases of one register. On such an access the low six data bits are captured. Five of them form the bank number and the sixth is a lock flag. Once the lock flag is stored, the selection is frozen until the next bus reset.

The read/write direction is not decoded on the port. An I/O read of the mapper therefore behaves like a write of all ones: it selects the highest bank, engages the lock if it is still open, and returns 0xFF. On the memory side, CPU address bit 15 is ignored, so the same 32 KB window appears in both halves of the 64 KB slot. The ROM chip select follows any memory read while the slot is selected.

Top module: `io_bank_mapper`

## Requirements
- R1: After an asynchronous reset (rst_ni low), bank_o is 0 and locked_o is 0.
- R2: A port access counts only when io_req_i is 1 and io_addr_i[7:3] is 0, whatever the value of io_addr_i[2:0]. Any other I/O address leaves bank_o and locked_o unchanged.
- R3: On a write access, bank_o takes io_wdata_i[4:0] and locked_o takes io_wdata_i[5]. Bits 7:6 are ignored.
- R4: A write with io_wdata_i[5]=1 loads its bank number in the same access that sets locked_o.
- R5: While locked_o is 1, no port access of any kind changes bank_o or locked_o.
- R6: A port access with io_we_i=0 acts as a write of 0xFF (bank 31, lock set) when unlocked, and io_rdata_o reads 0xFF during that access. io_rdata_o is 0x00 otherwise.
- R7: Each access updates the register once, on its first cycle. The new value is visible one clock after that cycle. Data that changes while io_req_i stays high is not taken.
- R8: rom_addr_o equals {bank_o, cpu_addr_i[14:0]}. cpu_addr_i[15] has no effect, so addresses 0x8000..0xFFFF mirror 0x0000..0x7FFF.
- R9: rom_cs_o is 1 exactly when slot_sel_i and mem_rd_i are both 1.
- R10: A reset applied while locked releases the lock, and a later write is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| io_req_i | input | 1 | I/O request, high for the whole access |
| io_we_i | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr_i | input | 8 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data (0xFF on a mapper read) |
| slot_sel_i | input | 1 | Slot select for the memory side |
| mem_rd_i | input | 1 | Memory read request |
| cpu_addr_i | input | 16 | CPU memory address |
| rom_addr_o | output | 20 | ROM byte address |
| rom_cs_o | output | 1 | ROM chip select |
| bank_o | output | 5 | Current bank number |
| locked_o | output | 1 | Lock state |

## Verification
Writes go to several aliased ports and to near-miss addresses such as 0x08 and 0x80. This separates a decode on bits 7..3 from a decode on the full byte, or one that drops a bit. Data patterns with bits 7:6 set show whether the capture is 6 bits wide. A held access whose data changes mid-access shows whether the update fires on the edge of the access or on its level. A lock write, then writes and reads while locked, then reset, then a read while unlocked, together exercise the one-shot lock and the read-as-0xFF path. CPU addresses with and without bit 15 set show the mirroring.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int unsigned IO_AW    = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned BANK_W   = 5;
  localparam int unsigned OFS_W    = 15;
  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned PORT_LSB = 3;
endpackage

// File: rtl/port_decode.sv
module port_decode #(
  parameter int unsigned IO_AW    = 8,
  parameter int unsigned PORT_LSB = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_req_i,
  input  logic [IO_AW-1:0] io_addr_i,
  output logic             hit_o,
  output logic             strobe_o
);
  logic hit_q;

  assign hit_o    = io_req_i && (io_addr_i[IO_AW-1:PORT_LSB] == '0);
  assign strobe_o = hit_o && !hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_o;
  end
endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              locked_o
);
  localparam int unsigned LATCH_W = BANK_W + 1;

  logic [LATCH_W-1:0] latch_q, load_val;

  // undriven bus on a read floats high
  assign load_val = we_i ? wdata_i[LATCH_W-1:0] : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         latch_q <= '0;
    else if (strobe_i && !latch_q[BANK_W]) latch_q <= load_val;
  end

  assign bank_o   = latch_q[BANK_W-1:0];
  assign locked_o = latch_q[BANK_W];
endmodule

// File: rtl/rom_addr_gen.sv
module rom_addr_gen #(
  parameter int unsigned BANK_W = 5,
  parameter int unsigned OFS_W  = 15,
  parameter int unsigned CPU_AW = 16
) (
  input  logic                    slot_sel_i,
  input  logic                    mem_rd_i,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [CPU_AW-1:0]       cpu_addr_i,
  output logic [BANK_W+OFS_W-1:0] rom_addr_o,
  output logic                    rom_cs_o
);
  // upper CPU bits above the window are left undecoded (mirroring)
  assign rom_addr_o = {bank_i, cpu_addr_i[OFS_W-1:0]};
  assign rom_cs_o   = slot_sel_i && mem_rd_i;
endmodule

// File: rtl/io_bank_mapper.sv
module io_bank_mapper
  import bankmap_pkg::*;
#(
  parameter int unsigned P_IO_AW    = IO_AW,
  parameter int unsigned P_DATA_W   = DATA_W,
  parameter int unsigned P_BANK_W   = BANK_W,
  parameter int unsigned P_OFS_W    = OFS_W,
  parameter int unsigned P_CPU_AW   = CPU_AW,
  parameter int unsigned P_PORT_LSB = PORT_LSB
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         io_req_i,
  input  logic                         io_we_i,
  input  logic [P_IO_AW-1:0]           io_addr_i,
  input  logic [P_DATA_W-1:0]          io_wdata_i,
  output logic [P_DATA_W-1:0]          io_rdata_o,
  input  logic                         slot_sel_i,
  input  logic                         mem_rd_i,
  input  logic [P_CPU_AW-1:0]          cpu_addr_i,
  output logic [P_BANK_W+P_OFS_W-1:0]  rom_addr_o,
  output logic                         rom_cs_o,
  output logic [P_BANK_W-1:0]          bank_o,
  output logic                         locked_o
);
  logic hit, strobe;

  port_decode #(.IO_AW(P_IO_AW), .PORT_LSB(P_PORT_LSB)) u_dec (
    .clk_i, .rst_ni, .io_req_i, .io_addr_i,
    .hit_o(hit), .strobe_o(strobe)
  );

  bank_latch #(.DATA_W(P_DATA_W), .BANK_W(P_BANK_W)) u_latch (
    .clk_i, .rst_ni, .strobe_i(strobe), .we_i(io_we_i),
    .wdata_i(io_wdata_i), .bank_o, .locked_o
  );

  rom_addr_gen #(.BANK_W(P_BANK_W), .OFS_W(P_OFS_W), .CPU_AW(P_CPU_AW)) u_rom (
    .slot_sel_i, .mem_rd_i, .bank_i(bank_o), .cpu_addr_i, .rom_addr_o, .rom_cs_o
  );

  assign io_rdata_o = (hit && !io_we_i) ? '1 : '0;
endmodule

// File: rtl/io_bank_mapper_chk.sv
module io_bank_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_req_i,
  input logic        io_we_i,
  input logic [7:0]  io_addr_i,
  input logic [7:0]  io_rdata_o,
  input logic [15:0] cpu_addr_i,
  input logic [19:0] rom_addr_o,
  input logic [4:0]  bank_o,
  input logic        locked_o
);
  // R5
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> (locked_o && $stable(bank_o)));

  // R2
  miss_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_req_i || io_addr_i[7:3] != 5'd0) |=> ($stable(bank_o) && $stable(locked_o)));

  // R7
  change_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_o) |-> $past(io_req_i));

  // R6
  read_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_i && !io_we_i && io_addr_i[7:3] == 5'd0) |-> (io_rdata_o == 8'hFF));

  // R8
  mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[14:0] == cpu_addr_i[14:0]);
endmodule

bind io_bank_mapper io_bank_mapper_chk u_chk (
  .clk_i, .rst_ni, .io_req_i, .io_we_i, .io_addr_i, .io_rdata_o,
  .cpu_addr_i, .rom_addr_o, .bank_o, .locked_o
);

// File: tb/tb_io_bank_mapper.sv
`timescale 1ns/1ps
module tb_io_bank_mapper;
  logic        clk = 0, rst_n = 0;
  logic        io_req = 0, io_we = 0;
  logic [7:0]  io_addr = 0, io_wdata = 0, io_rdata;
  logic        slot_sel = 0, mem_rd = 0;
  logic [15:0] cpu_addr = 0;
  logic [19:0] rom_addr;
  logic        rom_cs;
  logic [4:0]  bank;
  logic        locked;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  io_bank_mapper dut (
    .clk_i(clk), .rst_ni(rst_n), .io_req_i(io_req), .io_we_i(io_we),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .slot_sel_i(slot_sel), .mem_rd_i(mem_rd), .cpu_addr_i(cpu_addr),
    .rom_addr_o(rom_addr), .rom_cs_o(rom_cs), .bank_o(bank), .locked_o(locked)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int  m_val = 0;
  bit  m_prev = 0;
  always @(posedge clk) begin
    bit h;
    if (!rst_n) begin m_val = 0; m_prev = 0; end
    else begin
      h = io_req && (io_addr < 8);
      if (h && !m_prev && m_val < 32) m_val = io_we ? (io_wdata % 64) : 63;
      m_prev = h;
    end
    #1;
    if (rst_n && !done) begin
      check("R3 model bank", bank, m_val % 32);
      check("R5 model lock", locked, m_val / 32);
      check("R8 rom_addr", rom_addr, (m_val % 32) * 32768 + (cpu_addr % 32768));
      check("R9 rom_cs", rom_cs, slot_sel & mem_rd);
    end
  end

  task automatic access(input logic [7:0] a, input logic [7:0] d, input logic we);
    @(negedge clk);
    io_req = 1; io_addr = a; io_wdata = d; io_we = we;
    #0.5 check("R6 rdata", io_rdata, (!we && a < 8) ? 8'hFF : 8'h00);
    @(negedge clk);
    io_req = 0; io_we = 0;
    @(negedge clk);
  endtask

  task automatic expect_state(string tag, int b, int l);
    check({tag, " bank"}, bank, b);
    check({tag, " lock"}, locked, l);
  endtask

  initial begin
    #(4*100000);
    $display("FAIL watchdog act=0 exp=1");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_state("R1 reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    expect_state("R1 after release", 0, 0);

    access(8'h03, 8'hC7, 1); expect_state("R2 R3 port3 write", 7, 0);
    access(8'h08, 8'h05, 1); expect_state("R2 miss 0x08", 7, 0);
    access(8'h80, 8'h05, 1); expect_state("R2 miss 0x80", 7, 0);
    access(8'h07, 8'h52, 1); expect_state("R2 R3 port7 write", 18, 0);

    // R7: held access, data changes mid-way
    @(negedge clk);
    io_req = 1; io_we = 1; io_addr = 8'h01; io_wdata = 8'h09;
    @(negedge clk);
    io_wdata = 8'h0C;
    repeat (3) @(negedge clk);
    expect_state("R7 held access", 9, 0);
    io_req = 0; io_we = 0;
    @(negedge clk);

    // R8 / R9
    cpu_addr = 16'h1234; slot_sel = 1; mem_rd = 1;
    #0.5 check("R8 low half", rom_addr, {5'd9, 15'h1234});
    check("R9 cs on", rom_cs, 1);
    @(negedge clk);
    cpu_addr = 16'h9234; mem_rd = 0;
    #0.5 check("R8 mirror", rom_addr, {5'd9, 15'h1234});
    check("R9 cs off", rom_cs, 0);
    @(negedge clk);
    slot_sel = 0;

    access(8'h02, 8'h2A, 1); expect_state("R4 lock write", 10, 1);
    access(8'h00, 8'h03, 1); expect_state("R5 write locked", 10, 1);
    access(8'h04, 8'h00, 0); expect_state("R5 read locked", 10, 1);

    @(negedge clk); rst_n = 0;
    @(negedge clk); expect_state("R10 reset clears", 0, 0);
    rst_n = 1;
    access(8'h06, 8'h11, 1); expect_state("R10 write after reset", 17, 0);

    access(8'h05, 8'h00, 0); expect_state("R6 read as FF", 31, 1);
    access(8'h10, 8'h00, 0); expect_state("R6 R2 read miss", 31, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule